// File: doc/BRIEF.md
# Speculative Line Tracking Buffer

This block records which cache lines a speculative region has touched through protected accesses. It is a small fully associative store of line addresses. Each entry carries a read-protect mark, a write-protect mark and, for lines the region has stored to, an undo copy of the line data as it was before the first speculative store. Remote coherence probes are compared against every entry at once. A probe that conflicts with the local protection aborts the local region, and the remote request is always allowed to proceed.

The core presents one access per cycle with a kind code, the line address and, for speculative stores, the prior line data. It also presents commit and abort commands. Commit empties the buffer in one cycle. An abort can come from software, from a conflicting probe or from running out of entries. On an abort the block walks its saved lines, drives each one on a write-back port for one cycle, empties the buffer and then pulses a done flag.

The controller has three states. TRACK accepts accesses, probes and commands. On any abort cause it moves to UNWIND. UNWIND emits one saved line per cycle. It moves to FINISH on the cycle it emits the last saved line, or at once if no line was saved. FINISH lasts one cycle, raises the done flag, and then returns to TRACK.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset the buffer is empty and `busy`, `region_abort`, `wb_valid`, `rollback_done` and `plain_clash` are 0, and `abort_why` is 0.
- R2: A line marked by a speculative load (`acc_kind`=0) or a monitor-read (`acc_kind`=2) is read-protected. A remote read (`prb_kind`=0) or prefetch (`prb_kind`=2) hitting it causes no abort. A remote write (`prb_kind`=1) or prefetch-for-write (`prb_kind`=3) hitting it aborts with `abort_why`=2 (conflict).
- R3: A line marked by a speculative store (`acc_kind`=1) or a monitor-write (`acc_kind`=3) is write-protected, and any probe kind hitting it aborts with `abort_why`=2.
- R4: An access to a line already held only updates that entry's marks and uses no new entry.
- R5: Eight distinct lines can be held with no abort. A tracking access to a ninth distinct line aborts with `abort_why`=3 (capacity).
- R6: The undo copy is `acc_old_data` from the first speculative store to a line. Later stores to that line leave it unchanged.
- R7: After an abort, the saved lines appear on `wb_valid`/`wb_addr`/`wb_data` one per cycle in ascending entry order, with entries filled lowest free index first. `rollback_done` is high for exactly the one cycle after the last write-back, or the second cycle after the abort when nothing was saved. The block then accepts a new region.
- R8: `cmd_commit` empties the buffer in one cycle with no write-back. Later probes to formerly held lines cause no abort.
- R9: A release (`acc_kind`=4) of a held line that has no undo copy removes it. A release of a line that has an undo copy has no effect.
- R10: A plain store (`acc_kind`=5) to a held line pulses `plain_clash` the next cycle without aborting. A plain store to a line not held does not pulse it.
- R11: `cmd_abort` aborts with `abort_why`=1. When several causes arise in one cycle, conflict wins over capacity, and capacity wins over software.
- R12: `region_abort` is a one-cycle pulse in the cycle after the cause. While `busy` is high, accesses, probes and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Local access present |
| acc_kind | input | 3 | 0 load, 1 store, 2 monitor-read, 3 monitor-write, 4 release, 5 plain store |
| acc_addr | input | ADDR_W | Line address of the access |
| acc_old_data | input | DATA_W | Prior line data for a speculative store |
| cmd_commit | input | 1 | Commit the region |
| cmd_abort | input | 1 | Software abort of the region |
| prb_valid | input | 1 | Remote probe present |
| prb_kind | input | 2 | 0 read, 1 write, 2 prefetch, 3 prefetch-for-write |
| prb_addr | input | ADDR_W | Line address of the probe |
| busy | output | 1 | Rollback in progress (UNWIND or FINISH) |
| region_abort | output | 1 | One-cycle abort pulse |
| abort_why | output | 2 | Cause of the last abort: 1 software, 2 conflict, 3 capacity |
| plain_clash | output | 1 | Illegal plain store seen |
| wb_valid | output | 1 | Write-back of a saved line |
| wb_addr | output | ADDR_W | Line address being restored |
| wb_data | output | DATA_W | Prior data being restored |
| rollback_done | output | 1 | Rollback finished |

## Verification
Inputs are driven after a falling edge and take effect at the next rising edge. `region_abort`, `abort_why` and `plain_clash` are registered and are due in the cycle right after that edge. The first write-back is also visible in that cycle, because the write-back port is driven from the UNWIND state. Each later saved line follows one cycle apart, and `rollback_done` comes one cycle after the last one. Every bench task advances exactly one edge per stimulus and samples on the following falling edge, so each check lands in the cycle where its result is due.

// File: rtl/spec_line_pkg.sv
package spec_line_pkg;

    typedef enum logic [2:0] {
        ACC_LOAD     = 3'd0,
        ACC_STORE    = 3'd1,
        ACC_MON_RD   = 3'd2,
        ACC_MON_WR   = 3'd3,
        ACC_RELEASE  = 3'd4,
        ACC_PLAIN_ST = 3'd5
    } acc_kind_e;

    typedef enum logic [1:0] {
        PRB_READ   = 2'd0,
        PRB_WRITE  = 2'd1,
        PRB_PREF   = 2'd2,
        PRB_PREF_W = 2'd3
    } prb_kind_e;

    typedef enum logic [1:0] {
        WHY_NONE     = 2'd0,
        WHY_SOFTWARE = 2'd1,
        WHY_CONFLICT = 2'd2,
        WHY_CAPACITY = 2'd3
    } abort_why_e;

    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_UNWIND = 2'd1,
        ST_FINISH = 2'd2
    } trk_state_e;

endpackage

// File: rtl/spec_line_match.sv
module spec_line_match #(
    parameter int N  = 8,
    parameter int AW = 26
) (
    input  logic [N-1:0]         live,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        query,
    output logic [N-1:0]         hits
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = live[g] && (tags[g] == query);
    end
endmodule

// File: rtl/spec_line_pick.sv
module spec_line_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
    import spec_line_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [2:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_old_data,
    input  logic              cmd_commit,
    input  logic              cmd_abort,
    input  logic              prb_valid,
    input  logic [1:0]        prb_kind,
    input  logic [ADDR_W-1:0] prb_addr,
    output logic              busy,
    output logic              region_abort,
    output logic [1:0]        abort_why,
    output logic              plain_clash,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              rollback_done
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    trk_state_e state_q, state_d;

    logic [ENTRIES-1:0]             live_q, rd_q, wr_q, undo_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][DATA_W-1:0] data_q;
    logic                           abort_q, clash_q;
    abort_why_e                     why_q;

    logic [ENTRIES-1:0] acc_hits, prb_hits;
    logic               acc_hit, free_found, undo_found;
    logic [IW-1:0]      hit_idx, free_idx, undo_idx, slot;
    logic [ENTRIES-1:0] undo_left;

    acc_kind_e acc_k;
    prb_kind_e prb_k;
    logic      tracking, is_track_acc, prb_wants_w, conflict, cap_fail, abort_now;
    abort_why_e why_now;

    assign acc_k = acc_kind_e'(acc_kind);
    assign prb_k = prb_kind_e'(prb_kind);

    spec_line_match #(.N(ENTRIES), .AW(ADDR_W)) i_acc_match (
        .live(live_q), .tags(tag_q), .query(acc_addr), .hits(acc_hits));
    spec_line_match #(.N(ENTRIES), .AW(ADDR_W)) i_prb_match (
        .live(live_q), .tags(tag_q), .query(prb_addr), .hits(prb_hits));

    spec_line_pick #(.N(ENTRIES)) i_hit_pick  (.req(acc_hits), .found(acc_hit),    .idx(hit_idx));
    spec_line_pick #(.N(ENTRIES)) i_free_pick (.req(~live_q),  .found(free_found), .idx(free_idx));
    spec_line_pick #(.N(ENTRIES)) i_undo_pick (.req(undo_q),   .found(undo_found), .idx(undo_idx));

    // Decision logic for the TRACK state.
    assign slot         = acc_hit ? hit_idx : free_idx;
    assign tracking     = (state_q == ST_TRACK);
    assign is_track_acc = acc_valid && (acc_k == ACC_LOAD || acc_k == ACC_STORE ||
                                        acc_k == ACC_MON_RD || acc_k == ACC_MON_WR);
    assign prb_wants_w  = (prb_k == PRB_WRITE) || (prb_k == PRB_PREF_W);
    assign conflict     = prb_valid && |(prb_hits & (wr_q | (rd_q & {ENTRIES{prb_wants_w}})));
    assign cap_fail     = is_track_acc && !acc_hit && !free_found;
    assign abort_now    = tracking && (conflict || cap_fail || cmd_abort);
    assign why_now      = conflict ? WHY_CONFLICT : (cap_fail ? WHY_CAPACITY : WHY_SOFTWARE);
    assign undo_left    = undo_q & ~(ENTRIES'(1) << undo_idx);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK:  if (abort_now) state_d = ST_UNWIND;
            ST_UNWIND: if (!undo_found || undo_left == '0) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_TRACK;
            default:   state_d = ST_TRACK;
        endcase
    end

    // Entry storage and registered flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= '0;
            rd_q    <= '0;
            wr_q    <= '0;
            undo_q  <= '0;
            tag_q   <= '0;
            data_q  <= '0;
            abort_q <= 1'b0;
            clash_q <= 1'b0;
            why_q   <= WHY_NONE;
        end else begin
            abort_q <= abort_now;
            clash_q <= tracking && acc_valid && (acc_k == ACC_PLAIN_ST) && acc_hit;
            if (abort_now) why_q <= why_now;
            unique case (state_q)
                ST_TRACK: begin
                    if (abort_now) begin
                        // Keep the entries for the rollback walk.
                    end else if (cmd_commit) begin
                        live_q <= '0;
                        rd_q   <= '0;
                        wr_q   <= '0;
                        undo_q <= '0;
                    end else if (is_track_acc) begin
                        if (!acc_hit) begin
                            live_q[slot] <= 1'b1;
                            tag_q[slot]  <= acc_addr;
                            rd_q[slot]   <= 1'b0;
                            wr_q[slot]   <= 1'b0;
                            undo_q[slot] <= 1'b0;
                        end
                        if (acc_k == ACC_LOAD || acc_k == ACC_MON_RD) begin
                            rd_q[slot] <= 1'b1;
                        end else begin
                            wr_q[slot] <= 1'b1;
                        end
                        if (acc_k == ACC_STORE && !(acc_hit && undo_q[slot])) begin
                            undo_q[slot] <= 1'b1;
                            data_q[slot] <= acc_old_data;
                        end
                    end else if (acc_valid && acc_k == ACC_RELEASE && acc_hit && !undo_q[hit_idx]) begin
                        live_q[hit_idx] <= 1'b0;
                        rd_q[hit_idx]   <= 1'b0;
                        wr_q[hit_idx]   <= 1'b0;
                    end
                end
                ST_UNWIND: begin
                    if (undo_found) undo_q[undo_idx] <= 1'b0;
                    if (!undo_found || undo_left == '0) begin
                        live_q <= '0;
                        rd_q   <= '0;
                        wr_q   <= '0;
                        undo_q <= '0;
                    end
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        busy          = (state_q != ST_TRACK);
        region_abort  = abort_q;
        abort_why     = why_q;
        plain_clash   = clash_q;
        wb_valid      = (state_q == ST_UNWIND) && undo_found;
        wb_addr       = tag_q[undo_idx];
        wb_data       = data_q[undo_idx];
        rollback_done = (state_q == ST_FINISH);
    end

endmodule

// File: rtl/spec_line_checker.sv
module spec_line_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_abort,
    input logic       busy,
    input logic       region_abort,
    input logic [1:0] abort_why,
    input logic       wb_valid,
    input logic       rollback_done
);
    // R7: write-back only while unwinding
    a_r7_wb_in_unwind: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (busy && !rollback_done));

    // R7: done lasts one cycle and returns to tracking
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_done |=> (!rollback_done && !busy));

    // R12: abort pulse comes with the rollback state and a cause
    a_r12_abort_busy: assert property (@(posedge clk) disable iff (!rst_n)
        region_abort |-> (busy && abort_why != 2'd0));

    // R12: abort pulse is one cycle wide
    a_r12_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        region_abort |=> !region_abort);

    // R11: software abort while tracking always aborts
    a_r11_sw_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_abort) |=> region_abort);
endmodule

bind spec_line_tracker spec_line_checker i_spec_line_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_abort    (cmd_abort),
    .busy         (busy),
    .region_abort (region_abort),
    .abort_why    (abort_why),
    .wb_valid     (wb_valid),
    .rollback_done(rollback_done)
);

// File: tb/test_spec_line_tracker.sv
module test_spec_line_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 26;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [2:0]    acc_kind = '0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_old_data = '0;
    logic          cmd_commit = 1'b0, cmd_abort = 1'b0;
    logic          prb_valid = 1'b0;
    logic [1:0]    prb_kind = '0;
    logic [AW-1:0] prb_addr = '0;
    logic          busy, region_abort, plain_clash, wb_valid, rollback_done;
    logic [1:0]    abort_why;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spec_line_tracker i_spec_line_tracker (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        acc_valid = 0; cmd_commit = 0; cmd_abort = 0; prb_valid = 0;
    endtask

    task automatic acc(input logic [2:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
        acc_valid = 1; acc_kind = k; acc_addr = a; acc_old_data = d;
        step();
        quiet();
    endtask

    task automatic probe(input logic [1:0] k, input logic [AW-1:0] a);
        prb_valid = 1; prb_kind = k; prb_addr = a;
        step();
        quiet();
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && busy; i++) step();
    endtask

    task automatic soft_abort();
        cmd_abort = 1;
        step();
        quiet();
    endtask

    task automatic t_reset();
        eq("R1", "busy", busy, 0);
        eq("R1", "abort", region_abort, 0);
        eq("R1", "why", abort_why, 0);
        eq("R1", "wb_valid", wb_valid, 0);
        eq("R1", "done", rollback_done, 0);
        eq("R1", "clash", plain_clash, 0);
    endtask

    task automatic t_shared();
        acc(0, 26'h100, 0);
        acc(2, 26'h200, 0);
        probe(0, 26'h100);
        eq("R2", "read probe on shared", region_abort, 0);
        probe(2, 26'h200);
        eq("R2", "prefetch on monitored", region_abort, 0);
        probe(1, 26'h100);
        eq("R2", "write probe abort", region_abort, 1);
        eq("R2", "conflict cause", abort_why, 2);
        drain();
        acc(0, 26'h300, 0);
        probe(3, 26'h300);
        eq("R2", "pref-write probe abort", region_abort, 1);
        drain();
    endtask

    task automatic t_owned();
        acc(3, 26'h400, 0);
        probe(0, 26'h400);
        eq("R3", "read probe on monitor-write", region_abort, 1);
        eq("R3", "cause", abort_why, 2);
        drain();
        acc(1, 26'h500, 64'h5);
        probe(2, 26'h500);
        eq("R3", "prefetch on stored", region_abort, 1);
        eq("R3", "wb addr", wb_addr, 26'h500);
        eq("R3", "wb data", wb_data, 64'h5);
        drain();
    endtask

    task automatic t_capacity();
        for (int i = 0; i < 8; i++) begin
            acc(0, AW'(26'h10 + i), 0);
            eq("R5", "no abort within eight lines", region_abort, 0);
        end
        acc(0, 26'h10, 0);
        acc(3, 26'h13, 0);
        eq("R4", "repeat access no new entry", region_abort, 0);
        acc(2, 26'h18, 0);
        eq("R5", "ninth line abort", region_abort, 1);
        eq("R5", "capacity cause", abort_why, 3);
        drain();
    endtask

    task automatic t_unwind();
        acc(1, 26'h20, 64'h11);
        acc(0, 26'h21, 0);
        acc(1, 26'h22, 64'h33);
        acc(1, 26'h20, 64'h99);
        soft_abort();
        eq("R12", "abort pulse", region_abort, 1);
        eq("R11", "software cause", abort_why, 1);
        eq("R7", "first wb valid", wb_valid, 1);
        eq("R7", "first wb addr", wb_addr, 26'h20);
        eq("R6", "first-store undo data", wb_data, 64'h11);
        step();
        eq("R12", "pulse one cycle", region_abort, 0);
        eq("R7", "second wb addr", wb_addr, 26'h22);
        eq("R7", "second wb data", wb_data, 64'h33);
        eq("R7", "done not yet", rollback_done, 0);
        step();
        eq("R7", "no wb after last", wb_valid, 0);
        eq("R7", "done pulse", rollback_done, 1);
        step();
        eq("R7", "done one cycle", rollback_done, 0);
        eq("R7", "back to tracking", busy, 0);
        acc(0, 26'h23, 0);
        probe(1, 26'h23);
        eq("R7", "new region tracks", region_abort, 1);
        drain();
        soft_abort();
        eq("R7", "empty abort no wb", wb_valid, 0);
        step();
        eq("R7", "empty abort done", rollback_done, 1);
        drain();
    endtask

    task automatic t_commit();
        acc(1, 26'h600, 64'h6);
        acc(0, 26'h601, 0);
        cmd_commit = 1;
        step();
        quiet();
        eq("R8", "commit no busy", busy, 0);
        eq("R8", "commit no abort", region_abort, 0);
        probe(1, 26'h600);
        eq("R8", "probe after commit", region_abort, 0);
        probe(1, 26'h601);
        eq("R8", "probe after commit 2", region_abort, 0);
        soft_abort();
        eq("R8", "nothing to restore", wb_valid, 0);
        drain();
    endtask

    task automatic t_release();
        acc(0, 26'h700, 0);
        acc(4, 26'h700, 0);
        probe(1, 26'h700);
        eq("R9", "released line not monitored", region_abort, 0);
        acc(1, 26'h701, 64'h7);
        acc(4, 26'h701, 0);
        probe(0, 26'h701);
        eq("R9", "release of stored line ignored", region_abort, 1);
        eq("R9", "undo kept", wb_data, 64'h7);
        drain();
    endtask

    task automatic t_plain();
        acc(0, 26'h800, 0);
        acc(5, 26'h800, 0);
        eq("R10", "clash flagged", plain_clash, 1);
        eq("R10", "clash no abort", region_abort, 0);
        acc(5, 26'h801, 0);
        eq("R10", "miss no clash", plain_clash, 0);
        cmd_commit = 1;
        step();
        quiet();
    endtask

    task automatic t_priority();
        acc(0, 26'h900, 0);
        cmd_abort = 1; prb_valid = 1; prb_kind = 1; prb_addr = 26'h900;
        step();
        quiet();
        eq("R11", "conflict over software", abort_why, 2);
        drain();
        for (int i = 0; i < 8; i++) acc(0, AW'(26'h30 + i), 0);
        cmd_abort = 1; acc(0, 26'h40, 0);
        eq("R11", "capacity over software", abort_why, 3);
        drain();
        for (int i = 0; i < 8; i++) acc(0, AW'(26'h30 + i), 0);
        prb_valid = 1; prb_kind = 3; prb_addr = 26'h31;
        acc(0, 26'h41, 0);
        eq("R11", "conflict over capacity", abort_why, 2);
        drain();
    endtask

    task automatic t_busy_ignore();
        acc(1, 26'hA00, 64'h1);
        acc(1, 26'hA01, 64'h2);
        soft_abort();
        eq("R12", "wb first", wb_addr, 26'hA00);
        acc_valid = 1; acc_kind = 1; acc_addr = 26'hA02; acc_old_data = 64'h3;
        prb_valid = 1; prb_kind = 1; prb_addr = 26'hA01; cmd_commit = 1;
        step();
        quiet();
        eq("R12", "probe ignored while busy", region_abort, 0);
        eq("R12", "commit ignored, wb continues", wb_addr, 26'hA01);
        drain();
        probe(1, 26'hA02);
        eq("R12", "access ignored while busy", region_abort, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_shared();
        t_owned();
        t_capacity();
        t_unwind();
        t_commit();
        t_release();
        t_plain();
        t_priority();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule